// File: doc/BRIEF.md
# LCD Panel Controller Register File

This block is the register and interrupt front end of a small LCD panel controller. A processor reaches it over a plain strobe bus: an address, a write strobe with write data, and a read-data word that follows the address with no wait states. It holds the panel control word, three timing words and a subpanel word. It also keeps three sticky status flags and drives one level-sensitive interrupt line from them.

The control word carries the panel on/off bit. Turning the panel off or on is the only register action that changes status. Two pulse inputs from the frame fetch engine set the sync-error and palette-loaded flags. Several read-back words carry hard-wired ones that software must tolerate. The status word cannot be written.

Top module: `lcd_regif`

## Requirements
- R1: A write to offset 0x00 stores load mode from bits 21:20, the colour-panel flag from bit 7, the 2-bit interrupt mask from bits 4:3, the mono flag from bit 1, the on bit from bit 0, and the written bits under mask 0x01cff300 as a free field. A read of 0x00 returns the colour-panel flag at both bit 23 and bit 7, load mode at 21:20, the mask at 4:3, mono at 1, on at 0 and the free field, all ORed with 0xfe000c34.
- R2: Offsets 0x04 and 0x08 each store the full written word, read as a dimension field in bits 9:0 and a timing field in bits 31:10. A read of 0x04 is ORed with 0x0000000f. A read of 0x08 returns the word unchanged.
- R3: Offset 0x0c stores the full word and reads it back ORed with 0xfc000000. Offset 0x14 stores the written word ANDed with 0xa1ffffff and reads it back as stored.
- R4: Offset 0x10 reads palette-loaded at bit 6, sync-error at bit 2 and frame-done at bit 0, with zeros elsewhere. Writes to 0x10 change nothing.
- R5: The interrupt is high exactly when frame-done is set with mask bit 0 set, or palette-loaded is set with mask bit 1 set, or sync-error is set. Sync-error has no mask.
- R6: A control write that turns the on bit from 1 to 0 clears sync-error. It also sets frame-done unless the newly written load mode is 1, in which case frame-done is left unchanged. Palette-loaded is not affected.
- R7: A control write that turns the on bit from 0 to 1 clears frame-done and palette-loaded. A write that does not change the on bit leaves all flags alone.
- R8: A sync-error pulse sets sync-error, and a palette-loaded pulse sets palette-loaded. Each one takes priority over a clear from an on-bit change in the same cycle.
- R9: After reset every stored field and flag is zero. Reads then give 0xfe000c34 at 0x00, 0x0000000f at 0x04, 0 at 0x08, 0xfc000000 at 0x0c, 0 at 0x10 and 0 at 0x14, and the interrupt is low.
- R10: Any other offset, including an offset that is not word aligned, reads as zero. A write to it changes no register and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write strobe; the write takes effect at the next rising clock edge |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational by default) |
| fetch_sync_err | input | 1 | One-cycle pulse from the fetch engine: sync error seen |
| fetch_pal_done | input | 1 | One-cycle pulse from the fetch engine: palette loaded |
| irq | output | 1 | Level interrupt |

## Verification
Two functions can act in the same cycle. One is the on-bit edge from a control write, which clears flags. The other is a set pulse from the fetch engine, which sets them. The bench provokes this in two ways. It raises the palette pulse in the same cycle as a write that turns the panel on, and it raises the sync pulse in the same cycle as a write that turns the panel off with load mode 1. It then requires the status word and the interrupt to show the set flag and, for the second case, an unchanged frame-done. A randomised phase drives bus writes and both pulses together and compares every cycle against a behavioural model, so other overlaps are judged against the same priority rule.

// File: rtl/lcd_regif_pkg.sv
package lcd_regif_pkg;
   localparam int DATA_W = 32;

   localparam logic [DATA_W-1:0] CTRL_FREE_MASK = 32'h01cff300;
   localparam logic [DATA_W-1:0] CTRL_ONES      = 32'hfe000c34;
   localparam logic [DATA_W-1:0] TIM0_ONES      = 32'h0000000f;
   localparam logic [DATA_W-1:0] TIM2_ONES      = 32'hfc000000;
   localparam logic [DATA_W-1:0] SUB_KEEP_MASK  = 32'ha1ffffff;

   localparam int OFS_CTRL = 'h00;
   localparam int OFS_TIM0 = 'h04;
   localparam int OFS_TIM1 = 'h08;
   localparam int OFS_TIM2 = 'h0c;
   localparam int OFS_STAT = 'h10;
   localparam int OFS_SUB  = 'h14;

   // load mode value that keeps frame-done untouched when the panel is turned off
   localparam logic [1:0] LM_NO_FRAME = 2'd1;

   typedef struct packed {
      logic [1:0]        load_mode;
      logic              colour;
      logic [1:0]        irq_mask;
      logic              mono;
      logic              on;
      logic [DATA_W-1:0] free;
   } ctrl_t;

   typedef struct packed {
      logic pal_done;
      logic sync_err;
      logic frame_done;
   } stat_t;
endpackage

// File: rtl/lcd_regif_regs.sv
module lcd_regif_regs
   import lcd_regif_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DIM_W  = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   wdata,
   output ctrl_t               ctrl,
   output logic [DATA_W-1:0]   tim [2],
   output logic [DATA_W-1:0]   tim2,
   output logic [DATA_W-1:0]   sub,
   output logic                on_rise,
   output logic                on_fall,
   output logic                fall_keeps_fd
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_TIM2 = ADDR_W'(OFS_TIM2);
   localparam logic [ADDR_W-1:0] A_SUB  = ADDR_W'(OFS_SUB);

   logic wr_ctrl;
   assign wr_ctrl       = wr_en && (addr == A_CTRL);
   assign on_rise       = wr_ctrl &&  wdata[0] && !ctrl.on;
   assign on_fall       = wr_ctrl && !wdata[0] &&  ctrl.on;
   assign fall_keeps_fd = (wdata[21:20] == LM_NO_FRAME);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else if (wr_ctrl) begin
         ctrl.load_mode <= wdata[21:20];
         ctrl.colour    <= wdata[7];
         ctrl.irq_mask  <= wdata[4:3];
         ctrl.mono      <= wdata[1];
         ctrl.on        <= wdata[0];
         ctrl.free      <= wdata & CTRL_FREE_MASK;
      end
   end

   // the two timing words share one layout
   for (genvar gi = 0; gi < 2; gi++) begin : g_tim
      localparam logic [ADDR_W-1:0] A_T = ADDR_W'(OFS_TIM0 + 4*gi);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        tim[gi] <= '0;
         else if (wr_en && (addr == A_T))   tim[gi] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tim2 <= '0;
         sub  <= '0;
      end else if (wr_en) begin
         if (addr == A_TIM2) tim2 <= wdata;
         if (addr == A_SUB)  sub  <= wdata & SUB_KEEP_MASK;
      end
   end
endmodule

// File: rtl/lcd_regif_status.sv
module lcd_regif_status
   import lcd_regif_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       on_rise,
   input  logic       on_fall,
   input  logic       fall_keeps_fd,
   input  logic       set_sync,
   input  logic       set_pal,
   input  logic [1:0] irq_mask,
   output stat_t      st,
   output logic       irq
);
   stat_t st_d;

   always_comb begin
      st_d = st;
      if (set_sync)     st_d.sync_err = 1'b1;
      else if (on_fall) st_d.sync_err = 1'b0;

      if (set_pal)      st_d.pal_done = 1'b1;
      else if (on_rise) st_d.pal_done = 1'b0;

      if (on_rise)                         st_d.frame_done = 1'b0;
      else if (on_fall && !fall_keeps_fd)  st_d.frame_done = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= '0;
      else        st <= st_d;
   end

   assign irq = st.sync_err
              | (st.frame_done & irq_mask[0])
              | (st.pal_done   & irq_mask[1]);
endmodule

// File: rtl/lcd_regif_rdmux.sv
module lcd_regif_rdmux
   import lcd_regif_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter bit RD_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  ctrl_t             ctrl,
   input  logic [DATA_W-1:0] tim [2],
   input  logic [DATA_W-1:0] tim2,
   input  logic [DATA_W-1:0] sub,
   input  stat_t             st,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] rd_c;

   always_comb begin
      rd_c = '0;
      case (addr)
         ADDR_W'(OFS_CTRL): begin
            rd_c        = ctrl.free | CTRL_ONES;
            rd_c[23]    = rd_c[23] | ctrl.colour;
            rd_c[21:20] = rd_c[21:20] | ctrl.load_mode;
            rd_c[7]     = rd_c[7] | ctrl.colour;
            rd_c[4:3]   = rd_c[4:3] | ctrl.irq_mask;
            rd_c[1]     = rd_c[1] | ctrl.mono;
            rd_c[0]     = rd_c[0] | ctrl.on;
         end
         ADDR_W'(OFS_TIM0): rd_c = tim[0] | TIM0_ONES;
         ADDR_W'(OFS_TIM1): rd_c = tim[1];
         ADDR_W'(OFS_TIM2): rd_c = tim2 | TIM2_ONES;
         ADDR_W'(OFS_STAT): begin
            rd_c[6] = st.pal_done;
            rd_c[2] = st.sync_err;
            rd_c[0] = st.frame_done;
         end
         ADDR_W'(OFS_SUB):  rd_c = sub;
         default:           rd_c = '0;
      endcase
   end

   if (RD_REG) begin : g_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rdata <= '0;
         else        rdata <= rd_c;
      end
   end else begin : g_comb
      assign rdata = rd_c;
   end
endmodule

// File: rtl/lcd_regif.sv
module lcd_regif
   import lcd_regif_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DIM_W  = 10,
   parameter bit RD_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              fetch_sync_err,
   input  logic              fetch_pal_done,
   output logic              irq
);
   if (ADDR_W < 5 || ADDR_W > 16) begin : g_bad_addr
      $error("lcd_regif: ADDR_W must be within 5..16");
   end
   if (DIM_W != 10) begin : g_bad_dim
      $error("lcd_regif: dimension field is fixed at 10 bits");
   end

   ctrl_t             ctrl_q;
   stat_t             st_q;
   logic [DATA_W-1:0] tim_q [2];
   logic [DATA_W-1:0] tim2_q, sub_q;
   logic              on_rise, on_fall, fall_keeps_fd;

   lcd_regif_regs #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .addr(bus_addr), .wdata(bus_wdata),
      .ctrl(ctrl_q), .tim(tim_q), .tim2(tim2_q), .sub(sub_q),
      .on_rise(on_rise), .on_fall(on_fall), .fall_keeps_fd(fall_keeps_fd)
   );

   lcd_regif_status u_status (
      .clk(clk), .rst_n(rst_n), .on_rise(on_rise), .on_fall(on_fall),
      .fall_keeps_fd(fall_keeps_fd), .set_sync(fetch_sync_err), .set_pal(fetch_pal_done),
      .irq_mask(ctrl_q.irq_mask), .st(st_q), .irq(irq)
   );

   lcd_regif_rdmux #(.ADDR_W(ADDR_W), .RD_REG(RD_REG)) u_rdmux (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .ctrl(ctrl_q), .tim(tim_q),
      .tim2(tim2_q), .sub(sub_q), .st(st_q), .rdata(bus_rdata)
   );
endmodule

// File: rtl/lcd_regif_chk.sv
module lcd_regif_chk
   import lcd_regif_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter bit RD_REG = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       bus_rdata,
   input logic              fetch_sync_err,
   input logic              fetch_pal_done,
   input logic              irq,
   input logic [2:0]        stat,
   input logic              panel_on
);
   logic is_ctrl, is_stat, mapped;
   assign is_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
   assign is_stat = (bus_addr == ADDR_W'(OFS_STAT));
   assign mapped  = is_ctrl || is_stat || (bus_addr == ADDR_W'(OFS_TIM0)) ||
                    (bus_addr == ADDR_W'(OFS_TIM1)) || (bus_addr == ADDR_W'(OFS_TIM2)) ||
                    (bus_addr == ADDR_W'(OFS_SUB));

   AST_CTRL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (!RD_REG && is_ctrl) |-> ((bus_rdata & CTRL_ONES) == CTRL_ONES)); // R1
   AST_STAT_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && is_stat && !fetch_sync_err && !fetch_pal_done) |=> $stable(stat)); // R4
   AST_SYNC_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
      stat[1] |-> irq); // R5
   AST_FALL_SETS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && is_ctrl && panel_on && !bus_wdata[0] && bus_wdata[21:20] != 2'd1) |=> stat[0]); // R6
   AST_RISE_CLEARS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && is_ctrl && !panel_on && bus_wdata[0]) |=> !stat[0]); // R7
   AST_SYNC_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_sync_err |=> stat[1]); // R8
   AST_PAL_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_pal_done |=> stat[2]); // R8
   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!RD_REG && !mapped) |-> (bus_rdata == '0)); // R10
endmodule

bind lcd_regif lcd_regif_chk #(.ADDR_W(ADDR_W), .RD_REG(RD_REG)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata), .fetch_sync_err(fetch_sync_err), .fetch_pal_done(fetch_pal_done),
   .irq(irq), .stat(st_q), .panel_on(ctrl_q.on)
);

// File: tb/lcd_regif_tb.sv
`timescale 1ns/1ps
module lcd_regif_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        fetch_sync_err = 1'b0;
   logic        fetch_pal_done = 1'b0;
   logic        irq;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   lcd_regif u_dut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .fetch_sync_err(fetch_sync_err), .fetch_pal_done(fetch_pal_done),
      .irq(irq)
   );

   // behavioural reference model
   int unsigned m_lm = 0, m_col = 0, m_mask = 0, m_mono = 0, m_on = 0, m_free = 0;
   int unsigned m_t0 = 0, m_t1 = 0, m_t2 = 0, m_sub = 0;
   int unsigned m_fd = 0, m_pd = 0, m_se = 0;

   function automatic int unsigned model_read(int unsigned a);
      case (a)
         'h00: return 32'hfe000c34 | m_free | (m_col << 23) | (m_lm << 20) | (m_col << 7)
                      | (m_mask << 3) | (m_mono << 1) | m_on;
         'h04: return m_t0 | 32'hf;
         'h08: return m_t1;
         'h0c: return m_t2 | 32'hfc000000;
         'h10: return (m_pd << 6) | (m_se << 2) | m_fd;
         'h14: return m_sub;
         default: return 0;
      endcase
   endfunction

   function automatic string tag_of(int unsigned a);
      case (a)
         'h00: return "R1";
         'h04, 'h08: return "R2";
         'h0c, 'h14: return "R3";
         'h10: return "R4";
         default: return "R10";
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_lm = 0; m_col = 0; m_mask = 0; m_mono = 0; m_on = 0; m_free = 0;
         m_t0 = 0; m_t1 = 0; m_t2 = 0; m_sub = 0; m_fd = 0; m_pd = 0; m_se = 0;
      end else begin
         bit cw, up, down;
         cw   = bus_we && bus_addr == 8'h00;
         up   = cw && bus_wdata[0] && m_on == 0;
         down = cw && !bus_wdata[0] && m_on == 1;
         if (down) begin
            m_se = 0;
            if (bus_wdata[21:20] != 2'd1) m_fd = 1;
         end
         if (up) begin m_fd = 0; m_pd = 0; end
         if (fetch_sync_err) m_se = 1;
         if (fetch_pal_done) m_pd = 1;
         if (bus_we) begin
            case (bus_addr)
               8'h00: begin
                  m_lm = bus_wdata[21:20]; m_col = bus_wdata[7]; m_mask = bus_wdata[4:3];
                  m_mono = bus_wdata[1]; m_on = bus_wdata[0]; m_free = bus_wdata & 32'h01cff300;
               end
               8'h04: m_t0 = bus_wdata;
               8'h08: m_t1 = bus_wdata;
               8'h0c: m_t2 = bus_wdata;
               8'h14: m_sub = bus_wdata & 32'ha1ffffff;
               default: ;
            endcase
         end
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         int unsigned er, ei;
         er = model_read(bus_addr);
         ei = ((m_fd & m_mask) & 1) | ((m_pd & (m_mask >> 1)) & 1) | m_se;
         total++;
         if (bus_rdata !== er) begin
            bad++;
            $display("FAIL %s (model) addr=%02h rdata=%08h expected=%08h",
                     tag_of(bus_addr), bus_addr, bus_rdata, er);
         end
         total++;
         if (irq !== ei[0]) begin
            bad++;
            $display("FAIL R5 (model) irq=%0b expected=%0b", irq, ei[0]);
         end
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d, bit s, bit p);
      @(negedge clk); #1;
      bus_we = 1'b1; bus_addr = a; bus_wdata = d; fetch_sync_err = s; fetch_pal_done = p;
      @(negedge clk); #1;
      bus_we = 1'b0; fetch_sync_err = 1'b0; fetch_pal_done = 1'b0;
   endtask

   task automatic pulse(bit s, bit p);
      @(negedge clk); #1;
      fetch_sync_err = s; fetch_pal_done = p;
      @(negedge clk); #1;
      fetch_sync_err = 1'b0; fetch_pal_done = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
      @(negedge clk); #1;
      bus_addr = a;
      #2;
      chk(tag, bus_rdata, exp);
   endtask

   task automatic irq_is(bit exp, string tag);
      #1;
      chk(tag, {31'd0, irq}, {31'd0, exp});
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      // R9 reset values, checked while reset is held
      rd(8'h00, 32'hfe000c34, "R9"); rd(8'h04, 32'h0000000f, "R9");
      rd(8'h08, 32'h0, "R9");        rd(8'h0c, 32'hfc000000, "R9");
      rd(8'h10, 32'h0, "R9");        rd(8'h14, 32'h0, "R9");
      irq_is(1'b0, "R9");
      @(negedge clk); #1; rst_n = 1'b1;

      // R1 enable with mask bit 1
      wr(8'h00, 32'h0000_0011, 0, 0);
      rd(8'h00, 32'hfe000c35, "R1");
      // R4 status write ignored
      wr(8'h10, 32'hffffffff, 0, 0);
      rd(8'h10, 32'h0, "R4");
      // R8 / R5 sync pulse raises unmasked interrupt
      pulse(1, 0);
      rd(8'h10, 32'h4, "R8"); irq_is(1'b1, "R5");
      pulse(0, 1);
      rd(8'h10, 32'h44, "R8");
      // R6 fall, load mode 0, mask bit 0
      wr(8'h00, 32'h0000_0008, 0, 0);
      rd(8'h10, 32'h41, "R6"); irq_is(1'b1, "R5");
      // R7 rise with palette pulse in same cycle (R8 priority)
      wr(8'h00, 32'h0000_0001, 0, 1);
      rd(8'h10, 32'h40, "R7"); irq_is(1'b0, "R5");
      // R6 fall with load mode 1 and sync pulse in same cycle (R8)
      wr(8'h00, 32'h0010_0000, 1, 0);
      rd(8'h10, 32'h44, "R6"); irq_is(1'b1, "R5");
      // R2 / R3 word layouts
      wr(8'h04, 32'habcde5a0, 0, 0); rd(8'h04, 32'habcde5af, "R2");
      wr(8'h08, 32'h000007ff, 0, 0); rd(8'h08, 32'h000007ff, "R2");
      wr(8'h0c, 32'h01234567, 0, 0); rd(8'h0c, 32'hfd234567, "R3");
      wr(8'h14, 32'hffffffff, 0, 0); rd(8'h14, 32'ha1ffffff, "R3");
      // R1 colour flag read at two places, no edge
      wr(8'h00, 32'h0000_0080, 0, 0);
      rd(8'h00, 32'hfe800cb4, "R1"); rd(8'h10, 32'h44, "R7");
      // R10 unmapped and misaligned
      wr(8'h18, 32'hffffffff, 0, 0); rd(8'h18, 32'h0, "R10");
      wr(8'h02, 32'h0, 0, 0);        rd(8'h02, 32'h0, "R10");
      rd(8'h14, 32'ha1ffffff, "R10"); rd(8'h00, 32'hfe800cb4, "R10");
      rd(8'h10, 32'h44, "R10");

      // randomised overlap of bus writes and fetch pulses, judged by the model
      for (int i = 0; i < 600; i++) begin
         @(negedge clk); #1;
         bus_we         = ($urandom % 3) == 0;
         bus_addr       = (($urandom % 4) == 0) ? 8'h00 : 8'(($urandom % 8) * 4);
         bus_wdata      = $urandom;
         fetch_sync_err = ($urandom % 9) == 0;
         fetch_pal_done = ($urandom % 7) == 0;
      end
      @(negedge clk); #1;
      bus_we = 1'b0; fetch_sync_err = 1'b0; fetch_pal_done = 1'b0;
      repeat (2) @(negedge clk);
      #1;
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule